// File: doc/BRIEF.md
# Bit-Serial Card Memory Core with Keyed Zone Erase

This block is the storage and access core of a synchronous serial memory card. There is no address bus. A bit pointer starts at zero on a card reset and moves forward one position for each clock step. The bit under the pointer always appears on the data output. A host reaches any bit by resetting the card and then issuing steps. Programming happens at the pointer: a program pulse with the data line low clears the addressed bit to 0. A program pulse with the data line high requests an erase, and erase sets bits to 1.

Erase rights are guarded. A stretch of addresses holds an erase key. While the pointer passes through that stretch, the data line turns around and the host supplies key bits. A compare session succeeds only if every supplied bit equals the stored key. Success raises an erase-enable flag that lasts until the next card reset. With the flag raised, one erase pulse at a dedicated flag-bit address sets the whole 512-bit application zone to 1. The flag bit itself keeps its value. The security fuse input selects the level. While the fuse is intact, an erase anywhere inside the zone also sets the aligned 16-bit word around the pointer, with no key needed. After the fuse is blown, that word erase is refused.

One system clock runs the block. The `step`, `card_rst` and `pgm` inputs are one-cycle qualifiers taken from the card contacts. A `step` pulse stands for one falling edge of the card clock.

Top module: `smem_core`

## Requirements
- R1: After the power-on reset (`rst_n` low), the pointer is 0 and the erase-enable flag is clear. Every bit reads 1, except bits 688..735, which hold the key parameter with key bit 0 at address 688.
- R2: A cycle with `card_rst` high returns the pointer to 0 and clears the erase-enable flag. This input takes priority over `step` and `pgm`.
- R3: A `step` cycle advances the pointer by one, and the pointer wraps from 1023 to 0. From the following cycle, `io_out` shows the bit at the new address.
- R4: `io_oe` is low while the pointer is inside the key stretch 688..735 and while `pgm` is high. It is high in every other case.
- R5: On each `step` inside the key stretch, the block compares `io_in` with the stored key bit. The flag is set by the step that leaves address 735, provided all 48 compares of the session matched.
- R6: A single mismatched key bit keeps the flag clear until the next `card_rst`.
- R7: A program cycle (`pgm` high, `io_in` low, no `step`, no `card_rst`) clears the addressed bit to 0 on the next cycle. In the key stretch the program cycle has no effect.
- R8: With the fuse intact (`fuse_blown` = 0), an erase cycle (`pgm` high, `io_in` high) at any address in 176..687 sets all 16 bits of the aligned word containing that address to 1.
- R9: With the flag set, an erase cycle at address 736 sets every bit of 176..687 to 1. Bit 736 and the bits outside the zone are left unchanged.
- R10: With the fuse blown, an erase cycle inside the zone changes nothing. An erase cycle at 736 without the flag changes nothing at either security level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| card_rst | input | 1 | Card reset contact: pointer to 0, flag cleared |
| step | input | 1 | One card-clock falling edge: advance the pointer |
| pgm | input | 1 | Program contact: write or erase at the pointer |
| fuse_blown | input | 1 | 1 selects the higher security level |
| io_in | input | 1 | Host value on the data contact |
| io_out | output | 1 | Stored bit at the pointer |
| io_oe | output | 1 | 1 when the block drives the data contact |

## Verification
The erase-enable flag is never visible at the ports, so a wrong flag state shows up only through an erase at address 736. A flag that was raised wrongly or never cleared lets a zone that should stay locked become all ones. A flag that failed to rise leaves zero bits in the zone. Either result can be read a single step sweep later. A pointer that is off by one moves every later read, and it also misplaces the `io_oe` turnaround at the key boundary. The data output shows that error on the very next cycle. A word erase that reaches the wrong word boundary, or a zone erase that touches bit 736, is caught by reading the zone end bits 176 and 687, their outside neighbour 175, and bit 736 itself.

// File: rtl/smem_pkg.sv
package smem_pkg;
   localparam int WORD_BITS = 16;
   localparam int WORD_LSB  = 4;

   typedef enum logic [1:0] {
      OP_NONE       = 2'd0,
      OP_WRITE      = 2'd1,
      OP_WORD_ERASE = 2'd2,
      OP_ZONE_ERASE = 2'd3
   } smem_op_e;
endpackage

// File: rtl/smem_addr_ctr.sv
module smem_addr_ctr #(
   parameter int MEM_BITS = 1024,
   parameter int AW       = $clog2(MEM_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          card_rst,
   input  logic          step,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] LAST = AW'(MEM_BITS - 1);

   initial begin
      assert (MEM_BITS > 16 && MEM_BITS <= (1 << AW))
         else $error("smem_addr_ctr: MEM_BITS does not fit AW");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        addr <= '0;
      else if (card_rst) addr <= '0;
      else if (step)     addr <= (addr == LAST) ? '0 : addr + AW'(1);
   end

   // card reset dominates any step
   p_card_rst_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      card_rst |=> (addr == '0));

   p_step_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !card_rst) |=>
         (addr == (($past(addr) == LAST) ? '0 : $past(addr) + AW'(1))));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !card_rst) |=> $stable(addr));
endmodule

// File: rtl/smem_key_gate.sv
module smem_key_gate #(
   parameter int AW       = 10,
   parameter int KEY_LO   = 688,
   parameter int KEY_BITS = 48
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          card_rst,
   input  logic          step,
   input  logic [AW-1:0] addr,
   input  logic          io_in,
   input  logic          key_bit,
   output logic          flag
);
   localparam logic [AW-1:0] K_FIRST = AW'(KEY_LO);
   localparam logic [AW-1:0] K_LAST  = AW'(KEY_LO + KEY_BITS - 1);

   logic all_ok;
   logic in_key;
   logic miss;

   initial begin
      assert (KEY_BITS > 0 && KEY_LO + KEY_BITS <= (1 << AW))
         else $error("smem_key_gate: key stretch outside address space");
   end

   assign in_key = (addr >= K_FIRST) && (addr <= K_LAST);
   assign miss   = (io_in != key_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         all_ok <= 1'b1;
         flag   <= 1'b0;
      end else if (card_rst) begin
         all_ok <= 1'b1;
         flag   <= 1'b0;
      end else if (step && in_key) begin
         if (miss) all_ok <= 1'b0;
         if (addr == K_LAST && all_ok && !miss) flag <= 1'b1;
      end
   end

   p_flag_rise_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(step && !card_rst && addr == K_LAST));

   p_mismatch_locks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !card_rst && in_key && miss && !flag) |=> !flag);

   p_rst_clears_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      card_rst |=> !flag);
endmodule

// File: rtl/smem_array.sv
module smem_array
   import smem_pkg::*;
#(
   parameter int                    MEM_BITS  = 1024,
   parameter int                    AW        = $clog2(MEM_BITS),
   parameter int                    ZONE_LO   = 176,
   parameter int                    ZONE_BITS = 512,
   parameter int                    KEY_LO    = 688,
   parameter int                    KEY_BITS  = 48,
   parameter int                    FLAG_ADDR = 736,
   parameter logic [KEY_BITS-1:0]   KEY_INIT  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  smem_op_e      op,
   output logic          rd_bit
);
   localparam int NWORDS = MEM_BITS / WORD_BITS;
   localparam int WAW    = AW - WORD_LSB;

   logic [MEM_BITS-1:0] bits;

   initial begin
      assert (MEM_BITS % WORD_BITS == 0)
         else $error("smem_array: MEM_BITS not a whole number of words");
      assert (ZONE_LO % WORD_BITS == 0 && ZONE_BITS % WORD_BITS == 0)
         else $error("smem_array: zone not word aligned");
      assert (FLAG_ADDR < MEM_BITS && FLAG_ADDR >= ZONE_LO + ZONE_BITS)
         else $error("smem_array: flag bit must sit above the zone");
   end

   function automatic logic [WORD_BITS-1:0] init_word(input int w);
      logic [WORD_BITS-1:0] v;
      for (int b = 0; b < WORD_BITS; b++) begin
         int a;
         a = w * WORD_BITS + b;
         if (a >= KEY_LO && a < KEY_LO + KEY_BITS) v[b] = KEY_INIT[a - KEY_LO];
         else                                      v[b] = 1'b1;
      end
      return v;
   endfunction

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam logic [WORD_BITS-1:0] INIT = init_word(w);
      localparam bit IN_ZONE = (w * WORD_BITS >= ZONE_LO) &&
                               (w * WORD_BITS <  ZONE_LO + ZONE_BITS);
      logic [WORD_BITS-1:0] q;
      logic                 hit;

      assign hit = (addr[AW-1:WORD_LSB] == WAW'(w));

      if (IN_ZONE) begin : g_zone
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= INIT;
            else begin
               case (op)
                  OP_WRITE:      if (hit) q[addr[WORD_LSB-1:0]] <= 1'b0;
                  OP_WORD_ERASE: if (hit) q <= '1;
                  OP_ZONE_ERASE: q <= '1;
                  default:       ;
               endcase
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= INIT;
            else if (hit && op == OP_WRITE) q[addr[WORD_LSB-1:0]] <= 1'b0;
         end
      end

      assign bits[w*WORD_BITS +: WORD_BITS] = q;
   end

   assign rd_bit = bits[addr];

   p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WRITE) |=> !bits[$past(addr)]);

   p_word_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WORD_ERASE) |=> bits[$past(addr)]);

   p_zone_all_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ZONE_ERASE) |=> (&bits[ZONE_LO +: ZONE_BITS]));

   p_flag_bit_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ZONE_ERASE) |=> $stable(bits[FLAG_ADDR]));
endmodule

// File: rtl/smem_core.sv
module smem_core
   import smem_pkg::*;
#(
   parameter int                  MEM_BITS  = 1024,
   parameter int                  ZONE_LO   = 176,
   parameter int                  ZONE_BITS = 512,
   parameter int                  KEY_LO    = 688,
   parameter int                  KEY_BITS  = 48,
   parameter int                  FLAG_ADDR = 736,
   parameter logic [KEY_BITS-1:0] KEY_INIT  = 48'h5A3C_96F0_C3A5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic card_rst,
   input  logic step,
   input  logic pgm,
   input  logic fuse_blown,
   input  logic io_in,
   output logic io_out,
   output logic io_oe
);
   localparam int            AW      = $clog2(MEM_BITS);
   localparam logic [AW-1:0] Z_FIRST = AW'(ZONE_LO);
   localparam logic [AW-1:0] Z_LAST  = AW'(ZONE_LO + ZONE_BITS - 1);
   localparam logic [AW-1:0] K_FIRST = AW'(KEY_LO);
   localparam logic [AW-1:0] K_LAST  = AW'(KEY_LO + KEY_BITS - 1);
   localparam logic [AW-1:0] F_ADDR  = AW'(FLAG_ADDR);

   initial begin
      assert (KEY_LO >= ZONE_LO + ZONE_BITS && FLAG_ADDR > KEY_LO + KEY_BITS - 1)
         else $error("smem_core: regions overlap");
   end

   logic [AW-1:0] addr;
   logic          rd_bit;
   logic          flag;
   logic          in_key, in_zone, at_flag, req;
   smem_op_e      op;

   smem_addr_ctr #(.MEM_BITS(MEM_BITS), .AW(AW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .step(step), .addr(addr));

   smem_key_gate #(.AW(AW), .KEY_LO(KEY_LO), .KEY_BITS(KEY_BITS)) u_key (
      .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .step(step), .addr(addr),
      .io_in(io_in), .key_bit(rd_bit), .flag(flag));

   smem_array #(
      .MEM_BITS(MEM_BITS), .AW(AW), .ZONE_LO(ZONE_LO), .ZONE_BITS(ZONE_BITS),
      .KEY_LO(KEY_LO), .KEY_BITS(KEY_BITS), .FLAG_ADDR(FLAG_ADDR),
      .KEY_INIT(KEY_INIT)) u_mem (
      .clk(clk), .rst_n(rst_n), .addr(addr), .op(op), .rd_bit(rd_bit));

   assign in_key  = (addr >= K_FIRST) && (addr <= K_LAST);
   assign in_zone = (addr >= Z_FIRST) && (addr <= Z_LAST);
   assign at_flag = (addr == F_ADDR);
   assign req     = pgm && !card_rst && !step;

   always_comb begin
      op = OP_NONE;
      if (req) begin
         if (!io_in) begin
            if (!in_key) op = OP_WRITE;
         end else if (at_flag && flag) begin
            op = OP_ZONE_ERASE;
         end else if (in_zone && !fuse_blown) begin
            op = OP_WORD_ERASE;
         end
      end
   end

   assign io_out = rd_bit;
   assign io_oe  = !in_key && !pgm;

   p_oe_off_entering_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !card_rst && addr == K_FIRST - AW'(1) && !pgm) |=> !io_oe);

   p_locked_erase_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && io_in && fuse_blown && !flag) |=> $stable(io_out));

   p_key_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !io_in && in_key) |=> $stable(io_out));
endmodule

// File: tb/sim_smem_core.sv
module sim_smem_core;
   localparam int MEM   = 1024;
   localparam int ZLO   = 176;
   localparam int ZHI   = 687;
   localparam int KLO   = 688;
   localparam int KBITS = 48;
   localparam int FLAG  = 736;
   localparam logic [KBITS-1:0] KEY = 48'h5A3C_96F0_C3A5;

   // vector table: address, action (0 read, 1 write, 2 erase), expected io_out
   localparam int NV = 7;
   localparam int V_ADDR [NV] = '{5, 5, 6, 200, 201, 201, 200};
   localparam int V_ACT  [NV] = '{0, 1, 0, 1,   1,   2,   0};
   localparam int V_EXP  [NV] = '{1, 0, 1, 0,   0,   1,   1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic card_rst = 1'b0, step = 1'b0, pgm = 1'b0, fuse_blown = 1'b0, io_in = 1'b0;
   logic io_out, io_oe;

   int n_chk = 0;
   int n_bad = 0;
   int cur = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   smem_core u0 (
      .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .step(step), .pgm(pgm),
      .fuse_blown(fuse_blown), .io_in(io_in), .io_out(io_out), .io_oe(io_oe));

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   function automatic string vtag(input int k);
      case (k)
         1, 3, 4: return "R7";
         5, 6:    return "R8";
         default: return "R3";
      endcase
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b (addr %0d)", tag, act, exp, cur);
      end
   endtask

   task automatic card_reset();
      card_rst = 1'b1;
      tick();
      card_rst = 1'b0;
      cur = 0;
   endtask

   task automatic do_step();
      step = 1'b1;
      tick();
      step = 1'b0;
      cur = (cur == MEM - 1) ? 0 : cur + 1;
   endtask

   // mode 0: correct key, 1: all zeros, 2: key with bit 7 flipped
   task automatic goto_addr(input int a, input int mode);
      card_reset();
      for (int i = 0; i < a; i++) begin
         if (cur >= KLO && cur < KLO + KBITS) begin
            if (mode == 1)      io_in = 1'b0;
            else if (mode == 2 && cur == KLO + 7) io_in = ~KEY[cur - KLO];
            else                io_in = KEY[cur - KLO];
         end else io_in = 1'b0;
         do_step();
      end
      io_in = 1'b0;
   endtask

   task automatic pgm_pulse(input logic v);
      pgm = 1'b1;
      io_in = v;
      tick();
      pgm = 1'b0;
      io_in = 1'b0;
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: power-on state, pointer at 0, erased bit, output enabled
      check("R1", io_out, 1'b1);
      check("R4", io_oe, 1'b1);

      // table walk, fuse intact
      for (int k = 0; k < NV; k++) begin
         goto_addr(V_ADDR[k], 0);
         if (V_ACT[k] == 1)      pgm_pulse(1'b0);
         else if (V_ACT[k] == 2) pgm_pulse(1'b1);
         check(vtag(k), io_out, V_EXP[k][0]);
      end

      // R3: wrap-around after a full sweep
      goto_addr(0, 0);
      pgm_pulse(1'b0);
      for (int i = 0; i < MEM; i++) do_step();
      check("R3", io_out, 1'b0);
      do_step();
      check("R3", io_out, 1'b1);

      // R2: card reset returns the pointer to bit 0 (bit 0 = 0, bit 6 = 1)
      goto_addr(6, 0);
      check("R2", io_out, 1'b1);
      card_reset();
      check("R2", io_out, 1'b0);

      // R4: turnaround at the key stretch and during program
      goto_addr(KLO - 1, 0);
      check("R4", io_oe, 1'b1);
      do_step();
      check("R4", io_oe, 1'b0);
      goto_addr(KLO + KBITS, 0);
      check("R4", io_oe, 1'b1);
      pgm = 1'b1;
      #1;
      check("R4", io_oe, 1'b0);
      pgm = 1'b0;
      tick();

      // R10: higher security level refuses word erase and unkeyed zone erase
      fuse_blown = 1'b1;
      goto_addr(300, 0);
      pgm_pulse(1'b0);
      check("R7", io_out, 1'b0);
      pgm_pulse(1'b1);
      check("R10", io_out, 1'b0);
      goto_addr(FLAG, 1);
      pgm_pulse(1'b1);
      goto_addr(300, 0);
      check("R10", io_out, 1'b0);

      // R6: one wrong key bit keeps the zone locked
      goto_addr(FLAG, 2);
      pgm_pulse(1'b1);
      goto_addr(300, 0);
      check("R6", io_out, 1'b0);

      // R7: program attempt in the key stretch must not alter the key
      goto_addr(KLO + 5, 0);
      pgm_pulse(1'b0);

      // R9 setup: zone ends, outside neighbour and flag bit cleared
      goto_addr(ZLO, 0);     pgm_pulse(1'b0);
      goto_addr(ZHI, 0);     pgm_pulse(1'b0);
      goto_addr(ZLO - 1, 0); pgm_pulse(1'b0);
      goto_addr(FLAG, 0);    pgm_pulse(1'b0);
      check("R7", io_out, 1'b0);

      // R5 and R9: correct key then zone erase
      goto_addr(FLAG, 0);
      pgm_pulse(1'b1);
      check("R9", io_out, 1'b0);
      goto_addr(300, 0);
      check("R5", io_out, 1'b1);
      goto_addr(ZLO, 0);
      check("R9", io_out, 1'b1);
      goto_addr(ZHI, 0);
      check("R9", io_out, 1'b1);
      goto_addr(ZLO - 1, 0);
      check("R9", io_out, 1'b0);

      // R2: a new card session drops the earlier erase right
      goto_addr(300, 0);
      pgm_pulse(1'b0);
      goto_addr(FLAG, 1);
      pgm_pulse(1'b1);
      goto_addr(300, 0);
      check("R2", io_out, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule